// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block sequences the two gate signals of a half-bridge power stage. It drives a low-side gate and a high-side gate alternately. The two gates have equal on-times, and a fixed dead interval separates every turn-off from the opposite turn-on. The switching period comes from a digital period input, which stands in for an analog oscillator setting. Periods longer than a build-time maximum are clamped, so the slowest switching rate is fixed and a smaller period value raises the frequency.

The high-side gate has a floating supply that is charged while the low-side gate conducts. For this reason the low side always starts first and switches alone until the supply-ready flag is seen. Dropping the run enable, which covers undervoltage, fault and dimming, parks both gates low on the next clock. A one-clock strobe marks every low-side turn-on, so a downstream over-current counter can count switching cycles.

Top module: `hb_gate_driver`

## Requirements
- R1: While `rst_i` is high, and on the clock edge after `run_en_i` is sampled low, `lo_o`, `ho_o` and `lo_rise_o` are all 0. The phase timing stops.
- R2: When running starts with no restart wait pending (see R10), the low-side gate is the first to turn on. `lo_o` goes high on the first edge that samples `run_en_i` high.
- R3: `lo_o` and `ho_o` are never 1 in the same cycle.
- R4: One switching period has four parts in this order: `lo_o` high for ON clocks, both gates low for DEAD_CYC clocks, `ho_o` high for ON clocks (when permitted), and both gates low for DEAD_CYC clocks. ON = floor(P/2) − DEAD_CYC, where P is the effective period.
- R5: `period_i` is sampled only on the edge where `lo_o` turns on. A change at any other time takes effect at the next low-side turn-on, so no pulse is shortened.
- R6: P = min(`period_i`, PER_MAX). If floor(P/2) ≤ DEAD_CYC, then ON = 1.
- R7: A high-side pulse occurs only if `hs_ready_i` is 1 on the edge where the high-side slot begins. Low-side timing is the same whether or not the pulse occurs.
- R8: If `hs_ready_i` falls while `ho_o` is high, the pulse still runs for its full ON clocks. Only later slots are suppressed.
- R9: `lo_rise_o` is high for exactly one clock: the first cycle of each low-side pulse.
- R10: After a stop that interrupts switching, at least DEAD_CYC clocks with both gates low pass before `lo_o` turns on again. After reset there is no such wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_en_i | input | 1 | Switching allowed when high |
| period_i | input | PER_W | Requested switching period in clocks |
| hs_ready_i | input | 1 | High-side floating supply is ready |
| lo_o | output | 1 | Low-side gate command |
| ho_o | output | 1 | High-side gate command |
| lo_rise_o | output | 1 | One-clock strobe at each low-side turn-on |

## Verification
Two decisions can land on the same clock edge.

The first pair is the high-side permission and the start of the high-side slot. The bench holds `hs_ready_i` low up to the cycle just before the slot begins and raises it on exactly that edge. The permission must be taken from that edge's sample: the pulse must appear and be full length.

The second pair is a stop request and a phase boundary. The bench drops `run_en_i` on the last cycle of a low-side pulse and again in the middle of a high-side pulse, then asks to run again at once. The judgement is that both gates are low on the next edge and that the restart waits out the dead interval.

The bench's own position-in-period model predicts every cycle, and the mismatches it reports are attributed to the requirement being exercised.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LO    = 3'd1,
    PH_DT_LH = 3'd2,
    PH_HO    = 3'd3,
    PH_DT_HL = 3'd4
  } hbd_phase_e;

  // On-time of each gate for a requested period: clamp the period to the
  // slowest allowed rate, split it in two, and remove one dead interval.
  function automatic int unsigned hbd_on_len(input int unsigned per,
                                             input int unsigned per_max,
                                             input int unsigned dead);
    int unsigned eff;
    int unsigned half;
    eff  = (per > per_max) ? per_max : per;
    half = eff >> 1;
    return (half > dead) ? (half - dead) : 1;
  endfunction

endpackage

// File: rtl/hbd_period_sel.sv
module hbd_period_sel
  import hbd_pkg::*;
#(
  parameter int PER_W    = 16,
  parameter int DEAD_CYC = 80,
  parameter int PER_MAX  = 1000
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [PER_W-1:0] period_i,
  output logic [PER_W-1:0] on_next_o,
  output logic [PER_W-1:0] on_cur_o
);

  localparam int unsigned RST_ON = hbd_on_len(PER_MAX, PER_MAX, DEAD_CYC);

  always_comb begin
    on_next_o = PER_W'(hbd_on_len(32'(period_i), PER_MAX, DEAD_CYC));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      on_cur_o <= PER_W'(RST_ON);
    end else if (load_i) begin
      on_cur_o <= on_next_o;
    end
  end

endmodule

// File: rtl/hbd_phase_seq.sv
module hbd_phase_seq
  import hbd_pkg::*;
#(
  parameter int PER_W    = 16,
  parameter int DEAD_CYC = 80
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_en_i,
  input  logic [PER_W-1:0] on_next_i,
  input  logic [PER_W-1:0] on_cur_i,
  output hbd_phase_e       ph_o,
  output hbd_phase_e       ph_nxt_o,
  output logic             lo_start_o,
  output logic             ho_start_o
);

  localparam logic [PER_W-1:0] DEAD_LAST = PER_W'(DEAD_CYC - 1);

  hbd_phase_e       ph_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    ph_nxt_o   = ph_q;
    cnt_d      = cnt_zero ? cnt_q : cnt_q - 1'b1;
    lo_start_o = 1'b0;
    ho_start_o = 1'b0;
    if (!run_en_i) begin
      ph_nxt_o = PH_IDLE;
      if (ph_q != PH_IDLE) begin
        cnt_d = DEAD_LAST;
      end
    end else if (cnt_zero) begin
      unique case (ph_q)
        PH_IDLE, PH_DT_HL: begin
          ph_nxt_o   = PH_LO;
          cnt_d      = on_next_i - 1'b1;
          lo_start_o = 1'b1;
        end
        PH_LO: begin
          ph_nxt_o = PH_DT_LH;
          cnt_d    = DEAD_LAST;
        end
        PH_DT_LH: begin
          ph_nxt_o   = PH_HO;
          cnt_d      = on_cur_i - 1'b1;
          ho_start_o = 1'b1;
        end
        PH_HO: begin
          ph_nxt_o = PH_DT_HL;
          cnt_d    = DEAD_LAST;
        end
        default: begin
          ph_nxt_o = PH_IDLE;
          cnt_d    = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_nxt_o;
      cnt_q <= cnt_d;
    end
  end

  assign ph_o = ph_q;

endmodule

// File: rtl/hbd_out_stage.sv
module hbd_out_stage
  import hbd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  hbd_phase_e ph_nxt_i,
  input  logic       lo_start_i,
  input  logic       ho_start_i,
  input  logic       hs_ready_i,
  output logic       lo_o,
  output logic       ho_o,
  output logic       lo_rise_o
);

  logic allow_q;
  logic allow_d;

  assign allow_d = ho_start_i ? hs_ready_i : allow_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      allow_q   <= 1'b0;
      lo_o      <= 1'b0;
      ho_o      <= 1'b0;
      lo_rise_o <= 1'b0;
    end else begin
      allow_q   <= allow_d;
      lo_o      <= (ph_nxt_i == PH_LO);
      ho_o      <= (ph_nxt_i == PH_HO) && allow_d;
      lo_rise_o <= lo_start_i;
    end
  end

endmodule

// File: rtl/hb_gate_driver.sv
module hb_gate_driver
  import hbd_pkg::*;
#(
  parameter int PER_W    = 16,
  parameter int DEAD_CYC = 80,
  parameter int PER_MAX  = 1000
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             hs_ready_i,
  output logic             lo_o,
  output logic             ho_o,
  output logic             lo_rise_o
);

  hbd_phase_e       ph_w;
  hbd_phase_e       ph_nxt_w;
  logic             lo_start_w;
  logic             ho_start_w;
  logic [PER_W-1:0] on_next_w;
  logic [PER_W-1:0] on_cur_w;

  hbd_period_sel #(
    .PER_W   (PER_W),
    .DEAD_CYC(DEAD_CYC),
    .PER_MAX (PER_MAX)
  ) u_per (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (lo_start_w),
    .period_i (period_i),
    .on_next_o(on_next_w),
    .on_cur_o (on_cur_w)
  );

  hbd_phase_seq #(
    .PER_W   (PER_W),
    .DEAD_CYC(DEAD_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .run_en_i  (run_en_i),
    .on_next_i (on_next_w),
    .on_cur_i  (on_cur_w),
    .ph_o      (ph_w),
    .ph_nxt_o  (ph_nxt_w),
    .lo_start_o(lo_start_w),
    .ho_start_o(ho_start_w)
  );

  hbd_out_stage u_out (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ph_nxt_i  (ph_nxt_w),
    .lo_start_i(lo_start_w),
    .ho_start_i(ho_start_w),
    .hs_ready_i(hs_ready_i),
    .lo_o      (lo_o),
    .ho_o      (ho_o),
    .lo_rise_o (lo_rise_o)
  );

endmodule

// File: rtl/hbd_checker.sv
module hbd_checker #(
  parameter int PER_W    = 16,
  parameter int DEAD_CYC = 80
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             hs_ready,
  input logic             lo,
  input logic             ho,
  input logic             lo_stb,
  input logic             lo_start,
  input logic [PER_W-1:0] on_cur
);

  localparam int GW = $clog2(DEAD_CYC + 2);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (lo || ho) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (int'(gap_q) < DEAD_CYC) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst) !(lo && ho));

  p_stop_low_r1: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!lo && !ho && !lo_stb));

  p_deadtime_r4: assert property (@(posedge clk) disable iff (rst)
    (($rose(lo) || $rose(ho)) && seen_q) |-> (int'(gap_q) >= DEAD_CYC));

  p_period_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(lo_start) |-> $stable(on_cur));

  p_ho_permit_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ho) |-> $past(hs_ready));

  p_strobe_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
    lo_stb |-> (lo && !$past(lo)));

  p_rise_has_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (lo && !$past(lo)) |-> lo_stb);

endmodule

bind hb_gate_driver hbd_checker #(
  .PER_W   (PER_W),
  .DEAD_CYC(DEAD_CYC)
) u_chk (
  .clk     (clk_i),
  .rst     (rst_i),
  .run_en  (run_en_i),
  .hs_ready(hs_ready_i),
  .lo      (lo_o),
  .ho      (ho_o),
  .lo_stb  (lo_rise_o),
  .lo_start(lo_start_w),
  .on_cur  (on_cur_w)
);

// File: tb/tb_hb_gate_driver.sv
module tb_hb_gate_driver;

  localparam int PER_W = 16;
  localparam int DEAD  = 80;
  localparam int PMAX  = 1000;

  logic             clk = 1'b0;
  logic             rst;
  logic             run_en;
  logic [PER_W-1:0] period;
  logic             hs_ready;
  logic             lo;
  logic             ho;
  logic             lo_stb;

  hb_gate_driver #(
    .PER_W   (PER_W),
    .DEAD_CYC(DEAD),
    .PER_MAX (PMAX)
  ) dut (
    .clk_i     (clk),
    .rst_i     (rst),
    .run_en_i  (run_en),
    .period_i  (period),
    .hs_ready_i(hs_ready),
    .lo_o      (lo),
    .ho_o      (ho),
    .lo_rise_o (lo_stb)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic  lo;
    logic  ho;
    logic  stb;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  // Reference model: position t within the current period.
  bit active = 1'b0;
  bit allow  = 1'b0;
  int t      = 0;
  int on     = 1;
  int cool   = 0;

  function automatic int exp_on(input int p);
    int eff;
    eff = (p < PMAX) ? p : PMAX;
    eff = eff / 2 - DEAD;
    return (eff < 1) ? 1 : eff;
  endfunction

  task automatic step(input bit r, input int p, input bit rd, input string tag);
    exp_t e;
    run_en   = r;
    period   = PER_W'(p);
    hs_ready = rd;
    e.lo  = 1'b0;
    e.ho  = 1'b0;
    e.stb = 1'b0;
    e.tag = tag;
    if (!r) begin
      if (active) cool = DEAD - 1;
      else if (cool > 0) cool--;
      active = 1'b0;
    end else if (!active) begin
      if (cool == 0) begin
        active = 1'b1;
        t      = 0;
        on     = exp_on(p);
        allow  = 1'b0;
        e.lo   = 1'b1;
        e.stb  = 1'b1;
      end else begin
        cool--;
      end
    end else begin
      t++;
      if (t == 2 * on + 2 * DEAD) begin
        t  = 0;
        on = exp_on(p);
      end
      if (t == on + DEAD) allow = rd;
      e.lo  = (t < on);
      e.stb = (t == 0);
      e.ho  = allow && (t >= on + DEAD) && (t < 2 * on + DEAD);
    end
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic steps(input int n, input bit r, input int p, input bit rd, input string tag);
    for (int i = 0; i < n; i++) step(r, p, rd, tag);
  endtask

  task automatic run_until(input int target, input int p, input bit rd, input string tag);
    int g;
    g = 0;
    while (!(active && t == target) && g < 4000) begin
      step(1'b1, p, rd, tag);
      g++;
    end
  endtask

  // Monitor: pops one expected sample per cycle, mid clock-high phase.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (lo !== e.lo || ho !== e.ho) begin
          errors++;
          $display("FAIL %s: lo/ho got %b/%b expected %b/%b", e.tag, lo, ho, e.lo, e.ho);
        end
        checks++;
        if (lo_stb !== e.stb) begin
          errors++;
          $display("FAIL R9 (%s): strobe got %b expected %b", e.tag, lo_stb, e.stb);
        end
        checks++;
        if (lo === 1'b1 && ho === 1'b1) begin
          errors++;
          $display("FAIL R3: lo/ho got 1/1 expected not both high");
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst      = 1'b1;
    run_en   = 1'b1;
    period   = PER_W'(400);
    hs_ready = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (lo !== 1'b0 || ho !== 1'b0 || lo_stb !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset got lo/ho/stb %b/%b/%b expected 0/0/0", lo, ho, lo_stb);
    end
    run_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    steps(10, 1'b0, 400, 1'b0, "R1 idle");
    // R2: start with supply not ready, LO alone (R7)
    step(1'b1, 400, 1'b0, "R2 start");
    steps(800, 1'b1, 400, 1'b0, "R7 hs not ready");
    // R7: ready rises exactly on the edge the HO slot begins
    run_until(on + DEAD - 1, 400, 1'b0, "R7 pre");
    step(1'b1, 400, 1'b1, "R7 coincident permit");
    steps(1200, 1'b1, 400, 1'b1, "R4 steady");
    // R5: period change in the middle of a period
    run_until(50, 400, 1'b1, "R5 pre");
    steps(1200, 1'b1, 300, 1'b1, "R5 new period");
    // R8: ready falls in the middle of a HO pulse
    run_until(on + DEAD + 10, 300, 1'b1, "R8 pre");
    steps(700, 1'b1, 300, 1'b0, "R8 ready drop");
    // R6: clamp, odd, and short periods
    steps(2500, 1'b1, 2000, 1'b1, "R6 clamp");
    steps(1000, 1'b1, 401, 1'b1, "R6 odd");
    steps(600, 1'b1, 100, 1'b1, "R6 short");
    // R1 and R10: stop on the last LO cycle, restart at once
    steps(500, 1'b1, 400, 1'b1, "R4 resettle");
    run_until(on - 1, 400, 1'b1, "R1 pre");
    step(1'b0, 400, 1'b1, "R1 stop at boundary");
    steps(3, 1'b0, 400, 1'b1, "R1 stopped");
    steps(500, 1'b1, 400, 1'b1, "R10 restart");
    // R1 and R10: stop in the middle of HO, restart immediately
    run_until(on + DEAD + 5, 400, 1'b1, "R10 pre");
    step(1'b0, 400, 1'b1, "R1 stop in HO");
    steps(600, 1'b1, 400, 1'b1, "R10 restart after HO");
    steps(5, 1'b0, 400, 1'b1, "R1 final stop");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule